// File: doc/BRIEF.md
# Reset-Latched Pin Continuity Test Controller

This block lets a board tester check that every signal pin of a chip is soldered down. The decision to enter the test is taken once, at the moment the chip's active-low reset is released. At that edge the block looks at two host-bus inputs, the active-low frame strobe and data bit 0. When both are low, the test mode is latched. When either one is high, normal operation is latched. The chosen mode then holds until the next reset release.

While test mode is active, the output enables that the core drives onto the chained pads are forced off, so every chained pad behaves as an input. A single designated pad stays an output. It carries a cascaded XNOR of all the chained pad inputs. The tester drives the pads one at a time and watches that designated pad flip, which proves each pad is in contact with the board. The reset pin, the supply pins and the designated pad itself are not part of the chain.

A separate power-on clear sets the mode to normal before the first reset release. Outside test mode, every pad passes the core's enables through unchanged, and the designated pad also carries its normal data and enable.

Top module: `bt_xnor_ctrl`

## Requirements
- R1: While `por_n` is low, `test_mode` is 0 (normal mode) regardless of the other inputs.
- R2: At a rising edge of `rst_n` with `frame_n` = 0 and `lad0` = 0, `test_mode` becomes 1.
- R3: At a rising edge of `rst_n` with `frame_n` = 1 or `lad0` = 1 (any of the three such combinations), `test_mode` becomes 0.
- R4: Between rising edges of `rst_n`, `test_mode` holds its value. This covers the whole time `rst_n` is low, and any change of `frame_n` or `lad0` while `rst_n` is high has no effect on it.
- R5: While `test_mode` is 1, every bit of `pad_oe` is 0 whatever `core_oe` is.
- R6: While `test_mode` is 1, `dsg_oe` is 1 and `dsg_out` equals the chain result.
- R7: The chain result is built as follows: stage 0 is `pad_in[0]`, and stage k is NOT(stage k-1 XOR `pad_in[k]`); the result is the last stage. Equivalently, the result equals the XOR of all `pad_in` bits, inverted when N_CHAIN is even. Changing any single `pad_in` bit inverts the result.
- R8: While `test_mode` is 0, `pad_oe` equals `core_oe`, `dsg_out` equals `dsg_core_out` and `dsg_oe` equals `dsg_core_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on clear, active low; forces normal mode |
| rst_n | input | 1 | Chip reset, active low; its rising edge samples the mode request |
| frame_n | input | 1 | Host-bus frame strobe, active low |
| lad0 | input | 1 | Host-bus data bit 0 |
| pad_in | input | N_CHAIN | Input values of the chained pads |
| core_oe | input | N_CHAIN | Functional output enables from the core for the chained pads |
| dsg_core_out | input | 1 | Functional output data for the designated pad |
| dsg_core_oe | input | 1 | Functional output enable for the designated pad |
| test_mode | output | 1 | 1 while the continuity test mode is latched |
| pad_oe | output | N_CHAIN | Output enables delivered to the chained pads |
| dsg_out | output | 1 | Data delivered to the designated pad |
| dsg_oe | output | 1 | Output enable delivered to the designated pad |

## Verification
The only stored state is the mode flag, so `test_mode` is due directly after a `rst_n` rising edge or a `por_n` fall, with no clock involved. Every other output is a combinational function of the current inputs and the flag, so it is due in the same instant as its stimulus. The bench changes inputs on the falling edge of its 50 MHz clock and samples 5 ns later, well after the last change has settled and well away from any edge. After each reset release, the bench samples the flag on its own, before it applies any further stimulus.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic {
    MODE_FUNC  = 1'b0,
    MODE_BTEST = 1'b1
  } bt_mode_e;

  localparam int unsigned BT_CHAIN_DEFAULT = 8;
endpackage

// File: rtl/bt_mode_latch.sv
module bt_mode_latch
  import bt_pkg::*;
(
  input  logic por_n,
  input  logic rst_n,
  input  logic frame_n,
  input  logic lad0,
  output logic mode_q
);
  bt_mode_e mode_d;
  bt_mode_e mode_r;

  // next-state: request decoded from bus levels
  always_comb begin
    if (!frame_n && !lad0) mode_d = MODE_BTEST;
    else                   mode_d = MODE_FUNC;
  end

  // register: captured only at reset release, cleared at power-on
  always_ff @(posedge rst_n or negedge por_n) begin
    if (!por_n) mode_r <= MODE_FUNC;
    else        mode_r <= mode_d;
  end

  assign mode_q = (mode_r == MODE_BTEST);
endmodule

// File: rtl/bt_xnor_chain.sv
module bt_xnor_chain #(
  parameter int unsigned N_CHAIN = 8
) (
  input  logic [N_CHAIN-1:0] pad_in,
  output logic               chain_out
);
  localparam int unsigned LAST = N_CHAIN - 1;

  logic [N_CHAIN-1:0] stage;

  assign stage[0] = pad_in[0];

  for (genvar k = 1; k < N_CHAIN; k++) begin : g_stage
    assign stage[k] = ~(stage[k-1] ^ pad_in[k]);
  end

  assign chain_out = stage[LAST];
endmodule

// File: rtl/bt_pad_ovr.sv
module bt_pad_ovr #(
  parameter int unsigned N_CHAIN = 8
) (
  input  logic               test_en,
  input  logic [N_CHAIN-1:0] core_oe,
  input  logic               dsg_core_out,
  input  logic               dsg_core_oe,
  input  logic               chain_res,
  output logic [N_CHAIN-1:0] pad_oe,
  output logic               dsg_out,
  output logic               dsg_oe
);
  for (genvar i = 0; i < N_CHAIN; i++) begin : g_oe
    assign pad_oe[i] = core_oe[i] & ~test_en;
  end

  always_comb begin
    if (test_en) begin
      dsg_out = chain_res;
      dsg_oe  = 1'b1;
    end else begin
      dsg_out = dsg_core_out;
      dsg_oe  = dsg_core_oe;
    end
  end
endmodule

// File: rtl/bt_xnor_ctrl.sv
module bt_xnor_ctrl #(
  parameter int unsigned N_CHAIN = bt_pkg::BT_CHAIN_DEFAULT
) (
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               lad0,
  input  logic [N_CHAIN-1:0] pad_in,
  input  logic [N_CHAIN-1:0] core_oe,
  input  logic               dsg_core_out,
  input  logic               dsg_core_oe,
  output logic               test_mode,
  output logic [N_CHAIN-1:0] pad_oe,
  output logic               dsg_out,
  output logic               dsg_oe
);
  logic mode_q;
  logic chain_res;

  bt_mode_latch u_mode (
    .por_n   (por_n),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .lad0    (lad0),
    .mode_q  (mode_q)
  );

  bt_xnor_chain #(.N_CHAIN(N_CHAIN)) u_chain (
    .pad_in    (pad_in),
    .chain_out (chain_res)
  );

  bt_pad_ovr #(.N_CHAIN(N_CHAIN)) u_ovr (
    .test_en      (mode_q),
    .core_oe      (core_oe),
    .dsg_core_out (dsg_core_out),
    .dsg_core_oe  (dsg_core_oe),
    .chain_res    (chain_res),
    .pad_oe       (pad_oe),
    .dsg_out      (dsg_out),
    .dsg_oe       (dsg_oe)
  );

  assign test_mode = mode_q;
endmodule

// File: rtl/bt_xnor_ctrl_chk.sv
module bt_xnor_ctrl_chk #(
  parameter int unsigned N_CHAIN = 8
) (
  input logic               por_n,
  input logic               rst_n,
  input logic               frame_n,
  input logic               lad0,
  input logic [N_CHAIN-1:0] pad_in,
  input logic [N_CHAIN-1:0] core_oe,
  input logic               dsg_core_out,
  input logic               dsg_core_oe,
  input logic               test_mode,
  input logic [N_CHAIN-1:0] pad_oe,
  input logic               dsg_out,
  input logic               dsg_oe
);
  localparam logic EVEN_INV = ((N_CHAIN % 2) == 0);

  p_entry_r2: assert property (@(posedge rst_n) disable iff (!por_n)
    (!frame_n && !lad0) |=> test_mode);

  p_exit_r3: assert property (@(posedge rst_n) disable iff (!por_n)
    (frame_n || lad0) |=> !test_mode);

  always_comb begin
    if (por_n === 1'b1 && !$isunknown(test_mode) && !$isunknown(pad_in)
        && !$isunknown(core_oe)) begin
      if (test_mode) begin
        p_oe_off_r5: assert (pad_oe == '0);
        p_dsg_drive_r6: assert (dsg_oe == 1'b1);
        p_parity_r7: assert (dsg_out == ((^pad_in) ^ EVEN_INV));
      end else begin
        p_pass_r8: assert (pad_oe == core_oe && dsg_out == dsg_core_out
                           && dsg_oe == dsg_core_oe);
      end
    end
  end
endmodule

bind bt_xnor_ctrl bt_xnor_ctrl_chk #(.N_CHAIN(N_CHAIN)) u_chk (
  .por_n        (por_n),
  .rst_n        (rst_n),
  .frame_n      (frame_n),
  .lad0         (lad0),
  .pad_in       (pad_in),
  .core_oe      (core_oe),
  .dsg_core_out (dsg_core_out),
  .dsg_core_oe  (dsg_core_oe),
  .test_mode    (test_mode),
  .pad_oe       (pad_oe),
  .dsg_out      (dsg_out),
  .dsg_oe       (dsg_oe)
);

// File: tb/tb_bt_xnor_ctrl.sv
`timescale 1ns/1ps
module tb_bt_xnor_ctrl;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         por_n, rst_n, frame_n, lad0;
  logic [N-1:0] pad_in, core_oe;
  logic         dsg_core_out, dsg_core_oe;
  logic         test_mode, dsg_out, dsg_oe;
  logic [N-1:0] pad_oe;

  int total = 0;
  int bad   = 0;

  bt_xnor_ctrl #(.N_CHAIN(N)) dut (
    .por_n(por_n), .rst_n(rst_n), .frame_n(frame_n), .lad0(lad0),
    .pad_in(pad_in), .core_oe(core_oe), .dsg_core_out(dsg_core_out),
    .dsg_core_oe(dsg_core_oe), .test_mode(test_mode), .pad_oe(pad_oe),
    .dsg_out(dsg_out), .dsg_oe(dsg_oe)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected chain result from the parity form of R7
  function automatic logic ref_chain(input logic [N-1:0] v);
    return (^v) ^ ((N % 2) == 0);
  endfunction

  task automatic settle();
    #5;
  endtask

  // reset pulse with given bus levels at release; release on clk falling edge
  task automatic reset_pulse(input logic f, input logic d);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    frame_n = f;
    lad0    = d;
    @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_por();
    chk(test_mode === 1'b0, "R1", {31'd0, test_mode}, 32'd0);
    @(negedge clk);
    por_n = 1'b1;
    settle();
    chk(test_mode === 1'b0, "R1", {31'd0, test_mode}, 32'd0);
  endtask

  task automatic t_entry_exit();
    reset_pulse(1'b0, 1'b0);
    chk(test_mode === 1'b1, "R2 f0d0", {31'd0, test_mode}, 32'd1);
    reset_pulse(1'b1, 1'b0);
    chk(test_mode === 1'b0, "R3 f1d0", {31'd0, test_mode}, 32'd0);
    reset_pulse(1'b0, 1'b0);
    chk(test_mode === 1'b1, "R2 again", {31'd0, test_mode}, 32'd1);
    reset_pulse(1'b0, 1'b1);
    chk(test_mode === 1'b0, "R3 f0d1", {31'd0, test_mode}, 32'd0);
    reset_pulse(1'b0, 1'b0);
    reset_pulse(1'b1, 1'b1);
    chk(test_mode === 1'b0, "R3 f1d1", {31'd0, test_mode}, 32'd0);
  endtask

  task automatic t_hold();
    reset_pulse(1'b0, 1'b0);
    // bus activity while running
    @(negedge clk); frame_n = 1'b1; lad0 = 1'b1; settle();
    chk(test_mode === 1'b1, "R4 run", {31'd0, test_mode}, 32'd1);
    // hold during asserted reset with exit levels present
    @(negedge clk); rst_n = 1'b0; settle();
    chk(test_mode === 1'b1, "R4 in reset", {31'd0, test_mode}, 32'd1);
    @(negedge clk); rst_n = 1'b1; settle();
    chk(test_mode === 1'b0, "R3 after hold", {31'd0, test_mode}, 32'd0);
    @(negedge clk); frame_n = 1'b0; lad0 = 1'b0; settle();
    chk(test_mode === 1'b0, "R4 run idle", {31'd0, test_mode}, 32'd0);
  endtask

  task automatic t_normal();
    logic [N-1:0] pats [3] = '{8'hA5, 8'h00, 8'hFF};
    reset_pulse(1'b1, 1'b0);
    foreach (pats[i]) begin
      @(negedge clk);
      core_oe = pats[i]; dsg_core_out = pats[i][0]; dsg_core_oe = ~pats[i][1];
      pad_in = ~pats[i];
      settle();
      chk(pad_oe === core_oe, "R8 oe", {24'd0, pad_oe}, {24'd0, core_oe});
      chk(dsg_out === dsg_core_out && dsg_oe === dsg_core_oe, "R8 dsg",
          {30'd0, dsg_out, dsg_oe}, {30'd0, dsg_core_out, dsg_core_oe});
    end
  endtask

  task automatic t_override();
    reset_pulse(1'b0, 1'b0);
    @(negedge clk);
    core_oe = '1; dsg_core_oe = 1'b0; dsg_core_out = 1'b0; pad_in = '0;
    settle();
    chk(pad_oe === '0, "R5", {24'd0, pad_oe}, 32'd0);
    chk(dsg_oe === 1'b1, "R6 oe", {31'd0, dsg_oe}, 32'd1);
    chk(dsg_out === ref_chain(pad_in), "R6 data", {31'd0, dsg_out},
        {31'd0, ref_chain(pad_in)});
  endtask

  task automatic t_chain_walk();
    logic prev;
    @(negedge clk); pad_in = '0; settle();
    prev = dsg_out;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); pad_in[k] = ~pad_in[k]; settle();
      chk(dsg_out === ~prev, "R7 toggle", {31'd0, dsg_out}, {31'd0, ~prev});
      prev = dsg_out;
    end
    for (int k = N - 1; k >= 0; k--) begin
      @(negedge clk); pad_in[k] = ~pad_in[k]; settle();
      chk(dsg_out === ~prev, "R7 untoggle", {31'd0, dsg_out}, {31'd0, ~prev});
      prev = dsg_out;
    end
  endtask

  task automatic t_chain_patterns();
    logic [N-1:0] v;
    for (int p = 0; p < 24; p++) begin
      v = N'((p * 37 + 11) ^ (p << 3));
      @(negedge clk); pad_in = v; core_oe = ~v; settle();
      chk(dsg_out === ref_chain(v), "R7 fold", {31'd0, dsg_out},
          {31'd0, ref_chain(v)});
      chk(pad_oe === '0, "R5 pattern", {24'd0, pad_oe}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; frame_n = 1'b1; lad0 = 1'b1;
    pad_in = '0; core_oe = '0; dsg_core_out = 1'b0; dsg_core_oe = 1'b0;
    #5;
    t_por();
    t_entry_exit();
    t_hold();
    t_normal();
    t_override();
    t_chain_walk();
    t_chain_patterns();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule